// File: doc/BRIEF.md
# Storage Controller Register Interface

This block is the device-side register file of a queue-based storage controller. Host software reaches it through a plain 32-bit read/write register bus with byte addresses. The block holds the read-only capability and version words, the controller configuration word, the controller status word, an interrupt mask, the admin queue sizes and the two 64-bit admin queue base addresses. It also decodes doorbell writes for a parameterised number of queue pairs. The low control region sits below 0x1000, and the doorbells start at 0x1000. Within the doorbell area, tail and head slots interleave at a stride that the capability word advertises.

Two handshakes run inside the block. The first is enable/ready: the ready flag follows the enable bit after a programmable number of cycles. The second is the shutdown notification: a request moves the shutdown status to "in progress", and the controller core answers with a done strobe. A subsystem reset is raised only when one specific key value is written. The controller core sees the configuration fields, the queue setup, the doorbell pointers, the shutdown requests and the subsystem-reset pulse as plain output ports.

Top module: `stor_ctrl_regs`

## Requirements
- R1: After reset every writable register, the status word, ctrl_ready, shdn_status and every doorbell pointer are zero.
- R2: Offset 0x00 reads MQES in bits 15:0, a 1 in bit 16, the timeout in bits 31:24. Offset 0x04 reads the stride exponent in bits 3:0 and a 1 in bit 5. Offset 0x08 reads the version. Writes to 0x00, 0x04 and 0x08 change nothing.
- R3: The configuration word at 0x14 stores only the bits set in 0x00FFFFF1. Enable is bit 0 and the shutdown notification is bits 15:14. Other bits read 0. The whole word drives cfg_word.
- R4: ctrl_ready rises RDY_DELAY clock edges after the edge that sets enable. It falls on the first edge after enable is cleared. It reads as status bit 0 at 0x1C.
- R5: A write to 0x14 with enable 1 and shutdown code 1 (normal) or 2 (abrupt), made while the shutdown status is 0, sets the status to 1 on that edge. It also raises shdn_normal or shdn_abrupt. A shdn_done strobe then moves the status to 2. A write that clears enable returns it to 0. Code 3 is ignored. The shutdown status reads in bits 3:2 of 0x1C.
- R6: Writing 0x4E564D65 to 0x20 produces a one-cycle subsys_reset pulse and sets status bit 4. Any other value written there does neither. Writing 1 to bit 4 at 0x1C clears the bit.
- R7: Writing 1s to 0x0C sets those mask bits, and writing 1s to 0x10 clears them. Reads of either offset return the mask.
- R8: The queue attribute word at 0x24 keeps bits 11:0 (submission size) and 27:16 (completion size). Other bits read 0.
- R9: The admin submission base is at 0x28/0x2C and the completion base is at 0x30/0x34, each low word first. Bits 11:0 of each base always read and drive 0.
- R10: A write at 0x1000 + (2q+c)·(4<<DSTRD) loads data bits 15:0 into the submission tail of queue q when c=0, or the completion head when c=1. Doorbell reads return 0.
- R11: A doorbell write with q ≥ NUM_QP changes no pointer and raises db_err for one cycle.
- R12: bus_rdata presents the addressed word on the edge that samples bus_rd and holds it until the next read. Unmapped offsets read 0.
- R13: Status bits 1 and 5 reflect fatal_in and paused_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| fatal_in | input | 1 | Fatal condition from the core |
| paused_in | input | 1 | Processing-paused flag from the core |
| shdn_done | input | 1 | Core finished shutdown processing |
| ctrl_en | output | 1 | Enable bit |
| ctrl_ready | output | 1 | Ready flag |
| shdn_status | output | 2 | Shutdown status (0 idle, 1 busy, 2 done) |
| shdn_normal | output | 1 | Normal shutdown in progress |
| shdn_abrupt | output | 1 | Abrupt shutdown in progress |
| subsys_reset | output | 1 | Subsystem reset pulse |
| cfg_word | output | 32 | Configuration word image |
| int_mask | output | 32 | Interrupt mask |
| aq_sq_size | output | 12 | Admin submission queue size |
| aq_cq_size | output | 12 | Admin completion queue size |
| asq_base | output | 64 | Admin submission queue base |
| acq_base | output | 64 | Admin completion queue base |
| sq_tail | output | NUM_QP*16 | Submission tail pointers, queue q at bits 16q+15:16q |
| cq_head | output | NUM_QP*16 | Completion head pointers, same packing |
| db_err | output | 1 | Invalid doorbell pulse |

## Verification
The bench counts the cycles between setting enable and the ready flag. A counter that is off by one shows up as ready one edge early or one edge late. It steps the shutdown status through all three states and also tries the reserved code 3. A design that accepted code 3, or jumped straight to "complete", would show a wrong status at once. Near-miss values are written to the reset key, and random doorbell traffic spills past the last queue pair. These catch a decoder that swaps tail and head, wraps the queue number, or writes an out-of-range pointer instead of flagging it.

// File: rtl/stor_regs_pkg.sv
package stor_regs_pkg;
  localparam logic [7:0] OFF_CAP_LO = 8'h00;
  localparam logic [7:0] OFF_CAP_HI = 8'h04;
  localparam logic [7:0] OFF_VER    = 8'h08;
  localparam logic [7:0] OFF_IMSET  = 8'h0C;
  localparam logic [7:0] OFF_IMCLR  = 8'h10;
  localparam logic [7:0] OFF_CFG    = 8'h14;
  localparam logic [7:0] OFF_STAT   = 8'h1C;
  localparam logic [7:0] OFF_SSRST  = 8'h20;
  localparam logic [7:0] OFF_AQATTR = 8'h24;
  localparam logic [7:0] OFF_SQB_LO = 8'h28;
  localparam logic [7:0] OFF_SQB_HI = 8'h2C;
  localparam logic [7:0] OFF_CQB_LO = 8'h30;
  localparam logic [7:0] OFF_CQB_HI = 8'h34;

  localparam logic [31:0] SSRST_KEY = 32'h4E56_4D65;
  localparam logic [31:0] CFG_WMASK = 32'h00FF_FFF1;
  localparam logic [31:0] AQ_WMASK  = 32'h0FFF_0FFF;
  localparam int unsigned DB_BASE   = 32'h1000;
  localparam int unsigned QPTR_W    = 16;

  localparam logic [1:0] SHN_NORMAL = 2'd1;
  localparam logic [1:0] SHN_ABRUPT = 2'd2;

  typedef enum logic [1:0] {
    SHD_IDLE = 2'd0,
    SHD_BUSY = 2'd1,
    SHD_DONE = 2'd2
  } shd_state_e;
endpackage

// File: rtl/stor_cfg_regs.sv
module stor_cfg_regs
  import stor_regs_pkg::*;
#(
  parameter int RDY_DELAY = 4,
  localparam int CNT_W = $clog2(RDY_DELAY + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  input  logic        shdn_done,
  output logic [31:0] cc_q,
  output logic        ready,
  output logic [1:0]  shst,
  output logic [1:0]  shn_kind,
  output logic        nssro,
  output logic        ssrst_pulse,
  output logic [31:0] imask,
  output logic [31:0] aqa,
  output logic [63:0] asq,
  output logic [63:0] acq
);
  logic [CNT_W-1:0] rdy_cnt;
  shd_state_e       shd_q;
  logic [1:0]       shn_w;

  wire w_cfg   = wr && (addr == OFF_CFG);
  wire w_stat  = wr && (addr == OFF_STAT);
  wire w_ss    = wr && (addr == OFF_SSRST);
  wire w_ims   = wr && (addr == OFF_IMSET);
  wire w_imc   = wr && (addr == OFF_IMCLR);
  wire key_hit = w_ss && (wdata == SSRST_KEY);

  assign shn_w = wdata[15:14];
  assign shst  = shd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_q        <= '0;
      imask       <= '0;
      aqa         <= '0;
      asq         <= '0;
      acq         <= '0;
      nssro       <= 1'b0;
      ssrst_pulse <= 1'b0;
    end else begin
      ssrst_pulse <= key_hit;
      if (key_hit)                nssro <= 1'b1;
      else if (w_stat && wdata[4]) nssro <= 1'b0;
      if (w_cfg) cc_q <= wdata & CFG_WMASK;
      if (w_ims)      imask <= imask | wdata;
      else if (w_imc) imask <= imask & ~wdata;
      if (wr && addr == OFF_AQATTR) aqa <= wdata & AQ_WMASK;
      if (wr && addr == OFF_SQB_LO) asq[31:0]  <= {wdata[31:12], 12'h000};
      if (wr && addr == OFF_SQB_HI) asq[63:32] <= wdata;
      if (wr && addr == OFF_CQB_LO) acq[31:0]  <= {wdata[31:12], 12'h000};
      if (wr && addr == OFF_CQB_HI) acq[63:32] <= wdata;
    end
  end

  // enable -> ready delay counter
  always_ff @(posedge clk) begin
    if (rst || !cc_q[0]) begin
      rdy_cnt <= '0;
      ready   <= 1'b0;
    end else if (!ready) begin
      if (rdy_cnt == CNT_W'(RDY_DELAY - 1)) ready <= 1'b1;
      else                                  rdy_cnt <= rdy_cnt + 1'b1;
    end
  end

  // shutdown notification handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      shd_q    <= SHD_IDLE;
      shn_kind <= 2'd0;
    end else if (w_cfg && !wdata[0]) begin
      shd_q <= SHD_IDLE;
    end else if (w_cfg && (shn_w == SHN_NORMAL || shn_w == SHN_ABRUPT) && shd_q == SHD_IDLE) begin
      shd_q    <= SHD_BUSY;
      shn_kind <= shn_w;
    end else if (!cc_q[0]) begin
      shd_q <= SHD_IDLE;
    end else if (shd_q == SHD_BUSY && shdn_done) begin
      shd_q <= SHD_DONE;
    end
  end
endmodule

// File: rtl/stor_db_bank.sv
module stor_db_bank
  import stor_regs_pkg::*;
#(
  parameter int NUM_QP = 4,
  parameter int DSTRD  = 0,
  parameter int ADDR_W = 16,
  localparam int SLOT_SH = 2 + DSTRD
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr,
  input  logic                     hit,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [QPTR_W-1:0]        wdata,
  output logic [NUM_QP*QPTR_W-1:0] sq_tail,
  output logic [NUM_QP*QPTR_W-1:0] cq_head,
  output logic                     db_err
);
  logic [ADDR_W-1:0] off, slot, qid;
  logic              is_cq, in_range;

  always_comb begin
    off      = addr - ADDR_W'(DB_BASE);
    slot     = off >> SLOT_SH;
    qid      = slot >> 1;
    is_cq    = slot[0];
    in_range = qid < ADDR_W'(NUM_QP);
  end

  always_ff @(posedge clk) begin
    if (rst) db_err <= 1'b0;
    else     db_err <= wr && hit && !in_range;
  end

  for (genvar g = 0; g < NUM_QP; g++) begin : g_qp
    logic [QPTR_W-1:0] sq_r, cq_r;
    wire sel = wr && hit && in_range && (qid == ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        sq_r <= '0;
        cq_r <= '0;
      end else if (sel) begin
        if (is_cq) cq_r <= wdata;
        else       sq_r <= wdata;
      end
    end
    assign sq_tail[g*QPTR_W +: QPTR_W] = sq_r;
    assign cq_head[g*QPTR_W +: QPTR_W] = cq_r;
  end
endmodule

// File: rtl/stor_ctrl_regs.sv
module stor_ctrl_regs
  import stor_regs_pkg::*;
#(
  parameter int          NUM_QP    = 4,
  parameter int          DSTRD     = 0,
  parameter int          RDY_DELAY = 4,
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] MQES      = 16'd1023,
  parameter logic [7:0]  TMO       = 8'd20,
  parameter logic [31:0] VERSION   = 32'h0001_0400
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic                     fatal_in,
  input  logic                     paused_in,
  input  logic                     shdn_done,
  output logic                     ctrl_en,
  output logic                     ctrl_ready,
  output logic [1:0]               shdn_status,
  output logic                     shdn_normal,
  output logic                     shdn_abrupt,
  output logic                     subsys_reset,
  output logic [31:0]              cfg_word,
  output logic [31:0]              int_mask,
  output logic [11:0]              aq_sq_size,
  output logic [11:0]              aq_cq_size,
  output logic [63:0]              asq_base,
  output logic [63:0]              acq_base,
  output logic [NUM_QP*QPTR_W-1:0] sq_tail,
  output logic [NUM_QP*QPTR_W-1:0] cq_head,
  output logic                     db_err
);
  localparam logic [63:0] CAP_VAL = 64'(MQES) | (64'd1 << 16) | (64'(TMO) << 24)
                                  | (64'(DSTRD & 15) << 32) | (64'd1 << 37);

  logic [1:0]  shn_kind;
  logic        nssro;
  logic [31:0] aqa, stat_w;

  wire ctl_hit = (bus_addr[ADDR_W-1:8] == '0);
  wire db_hit  = (bus_addr >= ADDR_W'(DB_BASE));

  stor_cfg_regs #(.RDY_DELAY(RDY_DELAY)) u_cfg (
    .clk(clk), .rst(rst), .wr(bus_wr && ctl_hit), .addr(bus_addr[7:0]),
    .wdata(bus_wdata), .shdn_done(shdn_done), .cc_q(cfg_word),
    .ready(ctrl_ready), .shst(shdn_status), .shn_kind(shn_kind),
    .nssro(nssro), .ssrst_pulse(subsys_reset), .imask(int_mask),
    .aqa(aqa), .asq(asq_base), .acq(acq_base)
  );

  stor_db_bank #(.NUM_QP(NUM_QP), .DSTRD(DSTRD), .ADDR_W(ADDR_W)) u_db (
    .clk(clk), .rst(rst), .wr(bus_wr), .hit(db_hit), .addr(bus_addr),
    .wdata(bus_wdata[QPTR_W-1:0]), .sq_tail(sq_tail), .cq_head(cq_head),
    .db_err(db_err)
  );

  assign ctrl_en     = cfg_word[0];
  assign aq_sq_size  = aqa[11:0];
  assign aq_cq_size  = aqa[27:16];
  assign shdn_normal = (shdn_status == SHD_BUSY) && (shn_kind == SHN_NORMAL);
  assign shdn_abrupt = (shdn_status == SHD_BUSY) && (shn_kind == SHN_ABRUPT);
  assign stat_w      = {26'd0, paused_in, nssro, shdn_status, fatal_in, ctrl_ready};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (ctl_hit) begin
        case (bus_addr[7:0])
          OFF_CAP_LO:           bus_rdata <= CAP_VAL[31:0];
          OFF_CAP_HI:           bus_rdata <= CAP_VAL[63:32];
          OFF_VER:              bus_rdata <= VERSION;
          OFF_IMSET, OFF_IMCLR: bus_rdata <= int_mask;
          OFF_CFG:              bus_rdata <= cfg_word;
          OFF_STAT:             bus_rdata <= stat_w;
          OFF_AQATTR:           bus_rdata <= aqa;
          OFF_SQB_LO:           bus_rdata <= asq_base[31:0];
          OFF_SQB_HI:           bus_rdata <= asq_base[63:32];
          OFF_CQB_LO:           bus_rdata <= acq_base[31:0];
          OFF_CQB_HI:           bus_rdata <= acq_base[63:32];
          default:              bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/stor_ctrl_regs_chk.sv
module stor_ctrl_regs_chk
  import stor_regs_pkg::*;
#(
  parameter int NUM_QP = 4,
  parameter int ADDR_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     bus_wr,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [31:0]              bus_wdata,
  input logic                     ctrl_en,
  input logic                     ctrl_ready,
  input logic [1:0]               shdn_status,
  input logic                     subsys_reset,
  input logic                     db_err,
  input logic [NUM_QP*QPTR_W-1:0] sq_tail,
  input logic [NUM_QP*QPTR_W-1:0] cq_head
);
  p_ready_drops_r4: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> !ctrl_ready);

  p_shdn_no_skip_r5: assert property (@(posedge clk) disable iff (rst)
    shdn_status == 2'd0 |=> shdn_status != 2'd2);

  p_shdn_legal_r5: assert property (@(posedge clk) disable iff (rst)
    shdn_status != 2'd3);

  p_ssrst_single_r6: assert property (@(posedge clk) disable iff (rst)
    subsys_reset |=> !subsys_reset);

  p_ssrst_key_r6: assert property (@(posedge clk) disable iff (rst)
    subsys_reset |-> $past(bus_wr && bus_addr == ADDR_W'(OFF_SSRST) && bus_wdata == SSRST_KEY));

  p_dberr_src_r11: assert property (@(posedge clk) disable iff (rst)
    db_err |-> $past(bus_wr && bus_addr >= ADDR_W'(DB_BASE)));

  p_db_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(sq_tail) && $stable(cq_head));
endmodule

bind stor_ctrl_regs stor_ctrl_regs_chk #(.NUM_QP(NUM_QP), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .ctrl_en(ctrl_en), .ctrl_ready(ctrl_ready), .shdn_status(shdn_status),
  .subsys_reset(subsys_reset), .db_err(db_err), .sq_tail(sq_tail), .cq_head(cq_head)
);

// File: tb/tb_stor_ctrl_regs.sv
module tb_stor_ctrl_regs;
  localparam int NUM_QP = 4;
  localparam int DSTRD  = 0;
  localparam int RDLY   = 4;
  localparam int AW     = 16;
  localparam int QW     = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic fatal_in = 0, paused_in = 0, shdn_done = 0;
  logic ctrl_en, ctrl_ready, shdn_normal, shdn_abrupt, subsys_reset, db_err;
  logic [1:0] shdn_status;
  logic [31:0] cfg_word, int_mask;
  logic [11:0] aq_sq_size, aq_cq_size;
  logic [63:0] asq_base, acq_base;
  logic [NUM_QP*QW-1:0] sq_tail, cq_head;

  int nchk = 0, nerr = 0;
  bit finished = 0;
  logic pulse_ss, pulse_err;
  logic [31:0] rv;
  logic [15:0] m_sq [NUM_QP];
  logic [15:0] m_cq [NUM_QP];
  logic [31:0] m_mask;

  always #4 clk = ~clk;

  stor_ctrl_regs #(.NUM_QP(NUM_QP), .DSTRD(DSTRD), .RDY_DELAY(RDLY), .ADDR_W(AW),
                   .MQES(16'd1023), .TMO(8'd20), .VERSION(32'h0001_0400)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fatal_in(fatal_in),
    .paused_in(paused_in), .shdn_done(shdn_done), .ctrl_en(ctrl_en),
    .ctrl_ready(ctrl_ready), .shdn_status(shdn_status), .shdn_normal(shdn_normal),
    .shdn_abrupt(shdn_abrupt), .subsys_reset(subsys_reset), .cfg_word(cfg_word),
    .int_mask(int_mask), .aq_sq_size(aq_sq_size), .aq_cq_size(aq_cq_size),
    .asq_base(asq_base), .acq_base(acq_base), .sq_tail(sq_tail), .cq_head(cq_head),
    .db_err(db_err)
  );

  function automatic logic [AW-1:0] db_addr(input int q, input int c);
    return AW'(32'h1000 + ((2 * q + c) << (2 + DSTRD)));
  endfunction

  function automatic logic [63:0] exp_cap();
    return 64'd1023 | (64'd1 << 16) | (64'd20 << 24) | (64'(DSTRD) << 32) | (64'd1 << 37);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; pulse_ss = subsys_reset; pulse_err = db_err;
  endtask

  task automatic br(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic cmp_db(input string req);
    for (int q = 0; q < NUM_QP; q++) begin
      chk(req, 64'(sq_tail[q*QW +: QW]), 64'(m_sq[q]));
      chk(req, 64'(cq_head[q*QW +: QW]), 64'(m_cq[q]));
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    for (int q = 0; q < NUM_QP; q++) begin m_sq[q] = 0; m_cq[q] = 0; end
    m_mask = 0;
    repeat (4) @(negedge clk);
    rst = 0;

    // R1 reset state
    br(16'h14, rv); chk("R1 cfg", 64'(rv), 0);
    br(16'h1C, rv); chk("R1 status", 64'(rv), 0);
    br(16'h24, rv); chk("R1 aqa", 64'(rv), 0);
    br(16'h0C, rv); chk("R1 mask", 64'(rv), 0);
    chk("R1 ready", 64'(ctrl_ready), 0);
    chk("R1 shdn", 64'(shdn_status), 0);
    cmp_db("R1 doorbells");

    // R2 capability and version
    br(16'h00, rv); chk("R2 cap lo", 64'(rv), 64'(exp_cap() & 64'hFFFF_FFFF));
    br(16'h04, rv); chk("R2 cap hi", 64'(rv), exp_cap() >> 32);
    br(16'h08, rv); chk("R2 version", 64'(rv), 64'h0001_0400);
    bw(16'h00, 32'h0); bw(16'h08, 32'hFFFF_FFFF);
    br(16'h00, rv); chk("R2 cap ro", 64'(rv), 64'(exp_cap() & 64'hFFFF_FFFF));
    br(16'h08, rv); chk("R2 version ro", 64'(rv), 64'h0001_0400);

    // R3 configuration mask
    bw(16'h14, 32'hFFFF_FFFE);
    br(16'h14, rv); chk("R3 cfg mask", 64'(rv), 64'h00FF_FFF0);
    chk("R3 cfg_word", 64'(cfg_word), 64'h00FF_FFF0);
    chk("R3 en low", 64'(ctrl_en), 0);
    bw(16'h14, 32'h0);

    // R4 ready timing
    bw(16'h14, 32'h1);
    for (int i = 1; i < RDLY; i++) begin @(negedge clk); chk("R4 not yet ready", 64'(ctrl_ready), 0); end
    @(negedge clk); chk("R4 ready", 64'(ctrl_ready), 1);
    br(16'h1C, rv); chk("R4 status rdy", 64'(rv), 1);
    bw(16'h14, 32'h0);
    chk("R4 ready holds one edge", 64'(ctrl_ready), 1);
    @(negedge clk); chk("R4 ready drop", 64'(ctrl_ready), 0);

    // R5 shutdown handshake
    bw(16'h14, 32'h1 | (32'd1 << 14));
    chk("R5 busy", 64'(shdn_status), 1);
    chk("R5 normal req", 64'(shdn_normal), 1);
    chk("R5 abrupt idle", 64'(shdn_abrupt), 0);
    repeat (3) @(negedge clk);
    chk("R5 waits for done", 64'(shdn_status), 1);
    shdn_done = 1; @(negedge clk); shdn_done = 0;
    chk("R5 done", 64'(shdn_status), 2);
    br(16'h1C, rv); chk("R5 status field", 64'(rv[3:2]), 2);
    bw(16'h14, 32'h0);
    chk("R5 cleared by en", 64'(shdn_status), 0);
    bw(16'h14, 32'h1 | (32'd2 << 14));
    chk("R5 abrupt req", 64'(shdn_abrupt), 1);
    chk("R5 abrupt busy", 64'(shdn_status), 1);
    bw(16'h14, 32'h0);
    bw(16'h14, 32'h1 | (32'd3 << 14));
    chk("R5 code3 ignored", 64'(shdn_status), 0);
    bw(16'h14, 32'h0);

    // R6 subsystem reset key
    bw(16'h20, 32'h4E56_4D64);
    chk("R6 near key no pulse", 64'(pulse_ss), 0);
    br(16'h1C, rv); chk("R6 near key no flag", 64'(rv[4]), 0);
    bw(16'h20, 32'h4E56_4D65);
    chk("R6 pulse", 64'(pulse_ss), 1);
    @(negedge clk); chk("R6 pulse one cycle", 64'(subsys_reset), 0);
    br(16'h1C, rv); chk("R6 flag set", 64'(rv[4]), 1);
    bw(16'h1C, 32'h10);
    br(16'h1C, rv); chk("R6 flag cleared", 64'(rv[4]), 0);

    // R7 mask set/clear, random
    for (int i = 0; i < 24; i++) begin
      logic [31:0] d;
      d = $urandom;
      if ($urandom % 2) begin bw(16'h0C, d); m_mask = m_mask | d; end
      else begin bw(16'h10, d); m_mask = m_mask & ~d; end
      br((i % 2) ? 16'h0C : 16'h10, rv);
      chk("R7 mask", 64'(rv), 64'(m_mask));
    end

    // R8 queue attributes
    bw(16'h24, 32'hFFFF_FFFF);
    br(16'h24, rv); chk("R8 aqa mask", 64'(rv), 64'h0FFF_0FFF);
    chk("R8 sizes", {40'd0, aq_cq_size, aq_sq_size}, 64'hFFF_FFF);

    // R9 base addresses
    bw(16'h28, 32'h1234_5678); bw(16'h2C, 32'h9ABC_DEF0);
    bw(16'h30, 32'hFFFF_FFFF); bw(16'h34, 32'h0000_0001);
    chk("R9 asq", asq_base, 64'h9ABC_DEF0_1234_5000);
    chk("R9 acq", acq_base, 64'h0000_0001_FFFF_F000);
    br(16'h28, rv); chk("R9 asq lo read", 64'(rv), 64'h1234_5000);

    // R10 / R11 doorbells, directed
    bw(db_addr(0, 0), 32'hABCD_0011); m_sq[0] = 16'h0011;
    chk("R10 no err", 64'(pulse_err), 0);
    bw(db_addr(NUM_QP - 1, 1), 32'h0000_7FFE); m_cq[NUM_QP - 1] = 16'h7FFE;
    cmp_db("R10 directed");
    br(db_addr(0, 0), rv); chk("R10 read zero", 64'(rv), 0);
    bw(db_addr(NUM_QP, 0), 32'h0000_5555);
    chk("R11 err pulse", 64'(pulse_err), 1);
    @(negedge clk); chk("R11 err one cycle", 64'(db_err), 0);
    cmp_db("R11 ignored");

    // R10 / R11 doorbells, random
    for (int i = 0; i < 60; i++) begin
      int q, c;
      logic [15:0] v;
      q = int'($urandom % (NUM_QP + 2));
      c = int'($urandom % 2);
      v = 16'($urandom);
      bw(db_addr(q, c), {16'hDEAD, v});
      if (q < NUM_QP) begin
        if (c == 1) m_cq[q] = v; else m_sq[q] = v;
        chk("R10 random err", 64'(pulse_err), 0);
      end else begin
        chk("R11 random err", 64'(pulse_err), 1);
      end
      cmp_db("R10 random");
    end

    // R12 unmapped read
    br(16'h18, rv); chk("R12 unmapped", 64'(rv), 0);
    br(16'h0800, rv); chk("R12 unmapped high", 64'(rv), 0);
    @(negedge clk); chk("R12 rdata hold", 64'(bus_rdata), 0);

    // R13 core status inputs
    fatal_in = 1; paused_in = 1;
    br(16'h1C, rv); chk("R13 fatal/paused", 64'(rv), 64'h22);
    fatal_in = 0; paused_in = 0;
    br(16'h1C, rv); chk("R13 cleared", 64'(rv), 0);

    summary();
  end
endmodule